// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block feeds outgoing packets from host memory to a MAC. The host prepares a ring of eight-byte transmit descriptors. Each descriptor holds a 24-bit buffer address, a byte count, an ownership bit and first/last-buffer flags. The host then hands descriptors over by setting their ownership bit. While idle, the engine polls the descriptor at its current ring position after a programmable gap. When it owns that descriptor and the descriptor starts a packet, it fetches the buffer through a 16-bit word memory port and pushes the bytes one at a time into a transmit FIFO.

A packet may span several buffers. Before leaving a buffer that is not the last of its packet, the engine looks exactly one descriptor ahead. If that descriptor is owned, the engine hands the finished one back and continues into the next buffer. If it is not owned, the engine raises a chain error and waits for the MAC to report that its FIFO ran dry. A packet that ends normally takes its completion status from a separate retry/status block. Status is written into the final descriptor, with the error word written first when there is an error, and the ownership bit is released in the last write.

The FSM states are IDLE (poll gap), RD_CTRL (read control word), SKIP (return a descriptor that does not start a packet), RD_ADDR, RD_SIZE, DAT_RD (fetch a buffer word), DAT_PUSH (push bytes), LOOK (read the next control word), RELEASE (return a non-final descriptor), WAIT_STAT, DRAIN (wait for underrun after a chain error), WR_ERR (write the error word) and WR_CTRL (final control write). The transitions are:
- IDLE→RD_CTRL when the gap expires.
- RD_CTRL→IDLE if the descriptor is not owned.
- RD_CTRL→SKIP if it is owned but does not start a packet.
- RD_CTRL→RD_ADDR otherwise, then RD_ADDR→RD_SIZE→DAT_RD.
- DAT_RD⇄DAT_PUSH while bytes remain.
- DAT_PUSH→WAIT_STAT at the end of a last buffer, or DAT_PUSH→LOOK at the end of a non-final one.
- LOOK→RELEASE→RD_ADDR if the next descriptor is owned, or LOOK→DRAIN if it is not.
- DAT_RD/DAT_PUSH→WR_ERR on an underrun.
- DRAIN→WR_ERR on an underrun.
- WAIT_STAT→WR_ERR or WR_CTRL.
- WR_ERR→WR_CTRL, then WR_CTRL→IDLE and SKIP→IDLE, each advancing the ring index.

Top module: `txd_ring_engine`

## Requirements
- R1: While idle, the engine reads the control word (byte offset 2) of the current descriptor once per poll gap. If that word's ownership bit (bit 15) is 0, it writes nothing to the descriptor and pushes no bytes.
- R2: An owned descriptor whose first-buffer flag (control bit 9) is 0 is returned with only bit 15 cleared and the other control bits unchanged. No bytes are pushed, and the sticky output `nostart_err` is set.
- R3: The buffer address is {control[7:0], word at offset 0}. The byte count is the two's complement of bits 11:0 of the size word (offset 4). The engine pushes exactly that many bytes in rising address order, even when the start address is odd. Memory requests hold their address until acknowledged and are always word aligned.
- R4: `fifo_last` is 1 only with the final byte of a buffer whose last-buffer flag (control bit 8) is set.
- R5: At the end of a non-final buffer, the engine reads the next descriptor's control word. Only if that descriptor is owned does it return the current descriptor (bit 15 cleared, the rest unchanged) and continue with the next buffer.
- R6: On completion, the final control word is written as: bit 15 = 0; bit 14 = error summary; bit 13 = 0; bits 12/11/10 = multiple-retry, single-retry and deferred status; bits 9:0 unchanged. The engine never sets bit 15, and this write comes after the error word.
- R7: The error word (offset 6) is written only when the error summary is 1. Its layout is chain error (bit 15), underflow (bit 14), 0 (bit 13), late collision (bit 12), carrier loss (bit 11), retries exhausted (bit 10) and collision time (bits 9:0). The error summary is the OR of bits 15, 14, 12, 11 and 10. When there is no error the error word is left untouched.
- R8: If the next descriptor is not owned, the engine keeps the current descriptor until `mac_underrun` arrives. It then writes an error word of 0xC000 (chain error and underflow, all other status zero).
- R9: `mac_underrun` during a buffer fetch truncates the packet. The descriptor gets an error word of 0x4000 and no further bytes are pushed.
- R10: The size word (offset 4) is never written, and `fifo_wr` is never asserted while `fifo_full` is 1.
- R11: A non-final buffer shorter than 64 bytes, or a first non-final buffer shorter than 100 bytes, sets the sticky output `size_warn`. Processing of the packet continues normally.
- R12: Descriptor n lies at ring_base + 8n. The index advances after each returned or completed descriptor, modulo 2^RING_LOG2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Enables polling |
| ring_base | input | 24 | Ring start byte address (low 3 bits ignored) |
| poll_gap | input | GAPW | Idle cycles between polls |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 24 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| fifo_wr | output | 1 | Byte push |
| fifo_byte | output | 8 | Pushed byte |
| fifo_last | output | 1 | Final byte of a packet |
| fifo_full | input | 1 | FIFO cannot take a byte |
| mac_underrun | input | 1 | MAC drained the FIFO mid-packet |
| stat_valid | input | 1 | Completion status is available |
| stat_multi | input | 1 | More than one retry was needed |
| stat_single | input | 1 | Exactly one retry was needed |
| stat_defer | input | 1 | Transmission was deferred |
| stat_latecol | input | 1 | Late collision |
| stat_nocarrier | input | 1 | Carrier lost |
| stat_retryout | input | 1 | Retries exhausted |
| stat_colltime | input | 10 | Collision time count |
| size_warn | output | 1 | Sticky short-buffer warning |
| nostart_err | output | 1 | Sticky descriptor-without-start warning |

## Verification
The hardest state to reach is DRAIN. Getting there needs a packet that spans descriptors, a ring position just past it that the host still owns, and an underrun that arrives only after every byte of the first buffer has left. The bench arranges this by wrapping the ring onto a slot it returned earlier. It then waits for its scoreboard to empty and confirms that the descriptor is still held before it pulses the underrun. The underflow-only path is reached by holding the FIFO full, so that the engine is stuck in DAT_PUSH when the underrun arrives.

// File: rtl/txd_pkg.sv
package txd_pkg;
    localparam int ADDR_W = 24;

    localparam int OWNED_BIT = 15;
    localparam int ERRSUM_BIT = 14;
    localparam int FIRST_BIT = 9;
    localparam int LAST_BIT = 8;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_CTRL, S_SKIP, S_RD_ADDR, S_RD_SIZE, S_DAT_RD, S_DAT_PUSH,
        S_LOOK, S_RELEASE, S_WAIT_STAT, S_DRAIN, S_WR_ERR, S_WR_CTRL
    } txd_state_e;
endpackage

// File: rtl/txd_poll_timer.sv
module txd_poll_timer #(
    parameter int GAPW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [GAPW-1:0] gap,
    output logic            due
);
    logic [GAPW-1:0] cnt;

    assign due = (cnt >= gap);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm) begin
            cnt <= '0;
        end else if (!due) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/txd_len_check.sv
module txd_len_check #(
    parameter int CNT_W     = 12,
    parameter int MIN_MID   = 64,
    parameter int MIN_FIRST = 100
) (
    input  logic [CNT_W-1:0] bcnt,
    input  logic             first,
    input  logic             last,
    output logic [CNT_W:0]   len,
    output logic             short_viol
);
    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;

    assign len = FULL - {1'b0, bcnt};
    assign short_viol = !last &&
        ((len < (CNT_W+1)'(MIN_MID)) || (first && (len < (CNT_W+1)'(MIN_FIRST))));
endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine
    import txd_pkg::*;
#(
    parameter int RING_LOG2 = 2,
    parameter int GAPW      = 16,
    parameter int CNT_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [GAPW-1:0]   poll_gap,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              fifo_wr,
    output logic [7:0]        fifo_byte,
    output logic              fifo_last,
    input  logic              fifo_full,
    input  logic              mac_underrun,
    input  logic              stat_valid,
    input  logic              stat_multi,
    input  logic              stat_single,
    input  logic              stat_defer,
    input  logic              stat_latecol,
    input  logic              stat_nocarrier,
    input  logic              stat_retryout,
    input  logic [9:0]        stat_colltime,
    output logic              size_warn,
    output logic              nostart_err
);
    localparam int PADW  = ADDR_W - 3 - RING_LOG2;
    localparam int LEN_W = CNT_W + 1;

    txd_state_e           state;
    logic [RING_LOG2-1:0] idx, nidx;
    logic [15:0]          ctrl, nxt_ctrl, dword;
    logic [ADDR_W-1:0]    bufptr, base_al, cur_a, nxt_a;
    logic [LEN_W-1:0]     remain, blen;
    logic                 short_v, poll_due, err_sum;
    logic                 chain_err, under_err, multi_r, single_r, defer_r;
    logic                 latecol_r, nocar_r, rtryout_r;
    logic [9:0]           ctime_r;

    assign nidx    = idx + 1'b1;
    assign base_al = ring_base & ~ADDR_W'(7);
    assign cur_a   = base_al + {{PADW{1'b0}}, idx, 3'b000};
    assign nxt_a   = base_al + {{PADW{1'b0}}, nidx, 3'b000};
    assign err_sum = chain_err | under_err | latecol_r | nocar_r | rtryout_r;

    txd_poll_timer #(.GAPW(GAPW)) u_poll (
        .clk(clk), .rst_n(rst_n), .arm(run && (state == S_IDLE)),
        .gap(poll_gap), .due(poll_due)
    );

    txd_len_check #(.CNT_W(CNT_W)) u_len (
        .bcnt(mem_rdata[CNT_W-1:0]), .first(ctrl[FIRST_BIT]), .last(ctrl[LAST_BIT]),
        .len(blen), .short_viol(short_v)
    );

    // State register process: state, ring position and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx <= '0;
            ctrl <= '0;
            nxt_ctrl <= '0;
            dword <= '0;
            bufptr <= '0;
            remain <= '0;
            chain_err <= 1'b0;
            under_err <= 1'b0;
            multi_r <= 1'b0;
            single_r <= 1'b0;
            defer_r <= 1'b0;
            latecol_r <= 1'b0;
            nocar_r <= 1'b0;
            rtryout_r <= 1'b0;
            ctime_r <= '0;
            size_warn <= 1'b0;
            nostart_err <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (run && poll_due) state <= S_RD_CTRL;
                S_RD_CTRL: if (mem_ack) begin
                    ctrl <= mem_rdata;
                    chain_err <= 1'b0;
                    under_err <= 1'b0;
                    {multi_r, single_r, defer_r} <= 3'b000;
                    {latecol_r, nocar_r, rtryout_r} <= 3'b000;
                    ctime_r <= '0;
                    if (!mem_rdata[OWNED_BIT]) state <= S_IDLE;
                    else if (!mem_rdata[FIRST_BIT]) state <= S_SKIP;
                    else state <= S_RD_ADDR;
                end
                S_SKIP: if (mem_ack) begin
                    nostart_err <= 1'b1;
                    idx <= nidx;
                    state <= S_IDLE;
                end
                S_RD_ADDR: if (mem_ack) begin
                    bufptr <= {ctrl[7:0], mem_rdata};
                    state <= S_RD_SIZE;
                end
                S_RD_SIZE: if (mem_ack) begin
                    remain <= blen;
                    if (short_v) size_warn <= 1'b1;
                    state <= S_DAT_RD;
                end
                S_DAT_RD: begin
                    if (mac_underrun) begin
                        under_err <= 1'b1;
                        state <= S_WR_ERR;
                    end else if (mem_ack) begin
                        dword <= mem_rdata;
                        state <= S_DAT_PUSH;
                    end
                end
                S_DAT_PUSH: begin
                    if (mac_underrun) begin
                        under_err <= 1'b1;
                        state <= S_WR_ERR;
                    end else if (!fifo_full) begin
                        bufptr <= bufptr + 1'b1;
                        remain <= remain - 1'b1;
                        if (remain == LEN_W'(1))
                            state <= ctrl[LAST_BIT] ? S_WAIT_STAT : S_LOOK;
                        else if (bufptr[0])
                            state <= S_DAT_RD;
                    end
                end
                S_LOOK: if (mem_ack) begin
                    nxt_ctrl <= mem_rdata;
                    if (mem_rdata[OWNED_BIT]) begin
                        state <= S_RELEASE;
                    end else begin
                        chain_err <= 1'b1;
                        state <= S_DRAIN;
                    end
                end
                S_RELEASE: if (mem_ack) begin
                    idx <= nidx;
                    ctrl <= nxt_ctrl;
                    state <= S_RD_ADDR;
                end
                S_WAIT_STAT: if (stat_valid) begin
                    {multi_r, single_r, defer_r} <= {stat_multi, stat_single, stat_defer};
                    {latecol_r, nocar_r, rtryout_r} <= {stat_latecol, stat_nocarrier, stat_retryout};
                    ctime_r <= stat_colltime;
                    state <= (stat_latecol | stat_nocarrier | stat_retryout) ? S_WR_ERR : S_WR_CTRL;
                end
                S_DRAIN: if (mac_underrun) begin
                    under_err <= 1'b1;
                    state <= S_WR_ERR;
                end
                S_WR_ERR: if (mem_ack) state <= S_WR_CTRL;
                S_WR_CTRL: if (mem_ack) begin
                    idx <= nidx;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output process: memory and FIFO signals decoded from the state
    always_comb begin
        mem_req = 1'b0;
        mem_we = 1'b0;
        mem_addr = '0;
        mem_wdata = '0;
        fifo_wr = 1'b0;
        fifo_last = 1'b0;
        fifo_byte = bufptr[0] ? dword[15:8] : dword[7:0];
        unique case (state)
            S_RD_CTRL: begin
                mem_req = 1'b1;
                mem_addr = {cur_a[ADDR_W-1:3], 3'd2};
            end
            S_SKIP, S_RELEASE: begin
                mem_req = 1'b1;
                mem_we = 1'b1;
                mem_addr = {cur_a[ADDR_W-1:3], 3'd2};
                mem_wdata = {1'b0, ctrl[14:0]};
            end
            S_RD_ADDR: begin
                mem_req = 1'b1;
                mem_addr = cur_a;
            end
            S_RD_SIZE: begin
                mem_req = 1'b1;
                mem_addr = {cur_a[ADDR_W-1:3], 3'd4};
            end
            S_DAT_RD: begin
                mem_req = 1'b1;
                mem_addr = {bufptr[ADDR_W-1:1], 1'b0};
            end
            S_DAT_PUSH: begin
                fifo_wr = !fifo_full && !mac_underrun;
                fifo_last = ctrl[LAST_BIT] && (remain == LEN_W'(1));
            end
            S_LOOK: begin
                mem_req = 1'b1;
                mem_addr = {nxt_a[ADDR_W-1:3], 3'd2};
            end
            S_WR_ERR: begin
                mem_req = 1'b1;
                mem_we = 1'b1;
                mem_addr = {cur_a[ADDR_W-1:3], 3'd6};
                mem_wdata = {chain_err, under_err, 1'b0, latecol_r, nocar_r, rtryout_r, ctime_r};
            end
            S_WR_CTRL: begin
                mem_req = 1'b1;
                mem_we = 1'b1;
                mem_addr = {cur_a[ADDR_W-1:3], 3'd2};
                mem_wdata = {1'b0, err_sum, 1'b0, multi_r, single_r, defer_r, ctrl[9:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/txd_ring_engine_chk.sv
module txd_ring_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [23:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic        mem_ack,
    input logic        fifo_wr,
    input logic        fifo_full,
    input logic        mac_underrun,
    input logic        size_warn,
    input logic        nostart_err
);
    a_r6_never_grants: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr[2:0] == 3'd2) |-> !mem_wdata[15]);

    a_r6_ctrl_after_err_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && mem_addr[2:0] == 3'd6)
        |=> (mem_req && mem_we && mem_addr[2:0] == 3'd2));

    a_r7_err_word_only_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr[2:0] == 3'd6)
        |-> (!mem_wdata[13] && (|{mem_wdata[15:14], mem_wdata[12:10]})));

    a_r8_chain_err_has_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr[2:0] == 3'd6 && mem_wdata[15]) |-> mem_wdata[14]);

    a_r10_size_word_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[2:0] != 3'd4));

    a_r10_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !fifo_full);

    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mac_underrun)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    a_r11_size_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        size_warn |=> size_warn);

    a_r2_nostart_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        nostart_err |=> nostart_err);
endmodule

bind txd_ring_engine txd_ring_engine_chk u_chk (.*);

// File: tb/txd_ring_engine_test.sv
`timescale 1ns/1ps
module txd_ring_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [23:0] ring_base = 24'h000100;
    logic [15:0] poll_gap = 16'd6;
    logic        mem_req, mem_we, mem_ack;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        fifo_wr, fifo_last;
    logic [7:0]  fifo_byte;
    logic        fifo_full = 1'b0;
    logic        mac_underrun = 1'b0;
    logic        stat_valid = 1'b1;
    logic        stat_multi = 1'b0, stat_single = 1'b0, stat_defer = 1'b0;
    logic        stat_latecol = 1'b0, stat_nocarrier = 1'b0, stat_retryout = 1'b0;
    logic [9:0]  stat_colltime = '0;
    logic        size_warn, nostart_err;

    logic [15:0] mem [0:4095];
    logic [8:0]  exp_q [$];
    int          n_cmp = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    txd_ring_engine uut (
        .clk(clk), .rst_n(rst_n), .run(run), .ring_base(ring_base), .poll_gap(poll_gap),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .fifo_wr(fifo_wr), .fifo_byte(fifo_byte),
        .fifo_last(fifo_last), .fifo_full(fifo_full), .mac_underrun(mac_underrun),
        .stat_valid(stat_valid), .stat_multi(stat_multi), .stat_single(stat_single),
        .stat_defer(stat_defer), .stat_latecol(stat_latecol), .stat_nocarrier(stat_nocarrier),
        .stat_retryout(stat_retryout), .stat_colltime(stat_colltime),
        .size_warn(size_warn), .nostart_err(nostart_err)
    );

    function automatic int dw(int idx, int w);
        return ((32'h100 + idx * 8) >> 1) + w;
    endfunction

    // Memory responder: one cycle to acknowledge each request
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[(mem_addr >> 1) & 24'hFFF] <= mem_wdata;
            else mem_rdata <= mem[(mem_addr >> 1) & 24'hFFF];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Scoreboard monitor: every pushed byte must match the next expected one
    always @(negedge clk) begin
        if (rst_n && fifo_wr) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R3 unexpected byte act=%h exp=none", {fifo_last, fifo_byte});
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                if ({fifo_last, fifo_byte} !== e) begin
                    n_bad++;
                    $display("FAIL R3/R4 byte act=%h exp=%h", {fifo_last, fifo_byte}, e);
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_desc(int idx, int ladr, int len, bit first, bit last, bit own);
        mem[dw(idx, 0)] = 16'(ladr);
        mem[dw(idx, 1)] = {own, 5'b0, first, last, 8'h12};
        mem[dw(idx, 2)] = {4'hF, 12'(4096 - len)};
        mem[dw(idx, 3)] = 16'hABCD;
    endtask

    // Driver: fills a buffer and queues the bytes the engine should push
    task automatic load_buf(int a, int len, bit last, bit expect_push, int seed);
        for (int k = 0; k < len; k++) begin
            int ad;
            logic [7:0] b;
            ad = a + k;
            b = 8'((ad ^ 8'h5A) + seed);
            if (ad[0]) mem[(ad >> 1) & 12'hFFF][15:8] = b;
            else mem[(ad >> 1) & 12'hFFF][7:0] = b;
            if (expect_push) exp_q.push_back({last && (k == len - 1), b});
        end
    endtask

    task automatic wait_clear(int idx, string tag);
        bit done = 1'b0;
        for (int t = 0; t < 4000 && !done; t++) begin
            @(posedge clk); #1;
            if (!mem[dw(idx, 1)][15]) done = 1'b1;
        end
        if (!done) chk({tag, " release timeout"}, 0, 1);
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic wait_drained(string tag);
        bit done = 1'b0;
        for (int t = 0; t < 4000 && !done; t++) begin
            @(posedge clk); #1;
            if (exp_q.size() == 0) done = 1'b1;
        end
        if (!done) chk({tag, " drain timeout"}, 0, 1);
    endtask

    task automatic pulse_underrun();
        @(posedge clk); #1 mac_underrun = 1'b1;
        @(posedge clk); #1 mac_underrun = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        for (int i = 0; i < 4; i++) wr_desc(i, 0, 64, 1'b1, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset mem_req", 32'(mem_req), 0);
        chk("R10 reset fifo_wr", 32'(fifo_wr), 0);
        chk("R11 reset size_warn", 32'(size_warn), 0);
        chk("R2 reset nostart_err", 32'(nostart_err), 0);
        rst_n = 1'b1;
        run = 1'b1;

        // R3/R4: single buffer, odd start, index 0
        load_buf(24'h0401, 5, 1'b1, 1'b1, 3);
        wr_desc(0, 16'h0401, 5, 1'b1, 1'b1, 1'b1);
        wait_clear(0, "R3");
        chk("R3 all bytes pushed", exp_q.size(), 0);
        chk("R6 final control word", mem[dw(0, 1)], 16'h0312);
        chk("R7 error word untouched", mem[dw(0, 3)], 16'hABCD);
        chk("R10 size word untouched", mem[dw(0, 2)], 16'hFFFB);
        chk("R11 no warn for last buffer", 32'(size_warn), 0);

        // R5/R6/R7: two-buffer chain, status with one retry and retries exhausted
        stat_single = 1'b1;
        stat_retryout = 1'b1;
        stat_colltime = 10'h155;
        load_buf(24'h0600, 100, 1'b0, 1'b1, 7);
        load_buf(24'h0701, 3, 1'b1, 1'b1, 9);
        wr_desc(2, 16'h0701, 3, 1'b0, 1'b1, 1'b1);
        wr_desc(1, 16'h0600, 100, 1'b1, 1'b0, 1'b1);
        wait_clear(2, "R5");
        chk("R5 chain bytes pushed", exp_q.size(), 0);
        chk("R5 first buffer returned unchanged", mem[dw(1, 1)], 16'h0212);
        chk("R7 first buffer error word untouched", mem[dw(1, 3)], 16'hABCD);
        chk("R6 final control with status", mem[dw(2, 1)], 16'h4912);
        chk("R7 error word layout", mem[dw(2, 3)], 16'h0555);
        chk("R11 100-byte first buffer ok", 32'(size_warn), 0);
        stat_single = 1'b0;
        stat_retryout = 1'b0;
        stat_colltime = '0;

        // R1: index 3 not owned, engine just polls
        wr_desc(3, 16'h0B00, 10, 1'b0, 1'b1, 1'b0);
        repeat (200) @(posedge clk);
        #1;
        chk("R1 unowned descriptor untouched", mem[dw(3, 1)], 16'h0112);
        chk("R1 unowned error word untouched", mem[dw(3, 3)], 16'hABCD);
        // R2: owned without the first-buffer flag
        mem[dw(3, 1)][15] = 1'b1;
        wait_clear(3, "R2");
        chk("R2 skipped control word", mem[dw(3, 1)], 16'h0112);
        chk("R2 sticky flag", 32'(nostart_err), 1);

        // R8/R11/R12: index wraps to 0, short first buffer, next slot not owned
        load_buf(24'h0801, 80, 1'b0, 1'b1, 11);
        wr_desc(0, 16'h0801, 80, 1'b1, 1'b0, 1'b1);
        wait_drained("R8");
        repeat (30) @(posedge clk);
        #1;
        chk("R8 descriptor held until underrun", 32'(mem[dw(0, 1)][15]), 1);
        chk("R11 short first buffer warned", 32'(size_warn), 1);
        pulse_underrun();
        wait_clear(0, "R8");
        chk("R8 control after chain error", mem[dw(0, 1)], 16'h4212);
        chk("R8 error word", mem[dw(0, 3)], 16'hC000);
        chk("R12 next slot not touched", mem[dw(1, 1)], 16'h0212);

        // R9: underflow during fetch with FIFO held full
        fifo_full = 1'b1;
        load_buf(24'h0900, 10, 1'b1, 1'b0, 13);
        wr_desc(1, 16'h0900, 10, 1'b1, 1'b1, 1'b1);
        repeat (60) @(posedge clk);
        pulse_underrun();
        wait_clear(1, "R9");
        chk("R9 control after underflow", mem[dw(1, 1)], 16'h4312);
        chk("R9 error word", mem[dw(1, 3)], 16'h4000);
        fifo_full = 1'b0;
        repeat (50) @(posedge clk);
        #1;
        chk("R9 nothing pushed after truncation", exp_q.size(), 0);
        chk("R11 warn stays set", 32'(size_warn), 1);

        // R12: ring continues at index 2
        load_buf(24'h0A00, 4, 1'b1, 1'b1, 17);
        wr_desc(2, 16'h0A00, 4, 1'b1, 1'b1, 1'b1);
        wait_clear(2, "R12");
        chk("R12 index 2 completed", mem[dw(2, 1)], 16'h0312);
        chk("R12 bytes pushed", exp_q.size(), 0);

        repeat (20) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule